// File: doc/BRIEF.md
# Memory Access Range Coalescer

The block collects the memory accesses that one draw batch makes, each given as a start address and a byte count. It keeps them as a bounded list of ranges sorted by start address. After every new access it folds neighbouring ranges together when they overlap or when the gap between them is small. Typical access sizes are 1, 2 or 4 bytes, for example byte, short or float attribute fetches and 8-bit or 16-bit index fetches.

When the batch ends, a dump request streams the merged ranges out, lowest address first, over a valid/ready handshake. A last flag marks the final record. A batch-clear pulse empties the list before the next batch starts.

Each insertion takes several cycles: one to latch the access, one to place it in the list, and one per merge-scan step. A busy output stays high for the whole sequence, and access strobes are not taken while it is high. The list holds a fixed number of entries. An access that would need a new entry when the list is full is dropped and raises a sticky overflow flag.

Top module: `range_coalescer`

## Requirements
- R1: After reset the list is empty, overflow is low and busy is low. A dump request on an empty list produces no output record.
- R2: An access whose start address equals an entry already in the list does not add an entry. That entry's size becomes the larger of its old size and the new size.
- R3: Dumped records come out in strictly ascending start-address order, whatever order the accesses arrived in.
- R4: Two neighbouring ranges A then B merge when start(B) <= start(A) + size(A) + 32. A gap of exactly 32 bytes merges and a gap of 33 bytes does not.
- R5: When A absorbs B, A keeps its start and its size becomes max(size(A), start(B) + size(B) - start(A)). A range that lies fully inside another therefore leaves the larger range unchanged.
- R6: Merging repeats, so one insertion can fold a whole chain of following ranges into a single record.
- R7: The list holds at most 16 entries. An access that needs a 17th entry is dropped and sets overflow, which stays set until batch clear. An access that hits an existing start is still applied while the list is full.
- R8: Busy rises the cycle after an access strobe is taken and stays high until placement and merging finish. A strobe given while busy is high is ignored.
- R9: During a dump, each record stays valid with stable start and size until ready is seen. The last flag is high only on the final record. Busy stays high until the final record is taken.
- R10: A batch-clear pulse empties the list and clears overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| batch_clear | input | 1 | Empties the list and clears overflow |
| acc_valid | input | 1 | Access strobe, taken only while busy is low |
| acc_addr | input | 32 | Access start address |
| acc_size | input | 32 | Access size in bytes |
| dump_req | input | 1 | Starts streaming the list, taken only while busy is low |
| out_ready | input | 1 | Consumer accepts the current record |
| busy | output | 1 | Insertion or dump in progress |
| out_valid | output | 1 | A record is presented |
| out_start | output | 32 | Record start address |
| out_size | output | 32 | Record size in bytes |
| out_last | output | 1 | Record is the final one of the dump |
| overflow | output | 1 | Sticky: an access was dropped because the list was full |

## Verification
A fault in the list shows up at the ports only when the next dump runs. A broken shift or a wrong count gives records that are out of order, duplicated or missing. A wrong merge compare shows as a 32-byte or 33-byte gap resolved the wrong way. These show up in the first record after the bad entry, so every scenario ends with a dump. Faults in the control show up earlier, on busy: it rises a cycle late, falls before the merge scan ends, or lets a strobe given during the scan change the list.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PLACE = 2'd1,
    ST_MERGE = 2'd2,
    ST_DUMP  = 2'd3
  } rcState_t;

  typedef struct packed {
    logic clear;      // empty the list
    logic latch;      // capture the pending access
    logic place;      // put pending access into the list
    logic mergeStep;  // try to absorb the entry after the cursor
    logic settled;    // control is idle, list is fully merged
  } rcStrobe_t;
endpackage

// File: rtl/rc_datapath.sv
module rc_datapath import rc_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32,
  parameter int DEPTH  = 16,
  parameter int GAP    = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int EXT_W = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  rcStrobe_t         strobe,
  input  logic [IDX_W-1:0]  cursor,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [SIZE_W-1:0] accSize,
  output logic [CNT_W-1:0]  count,
  output logic              hit,
  output logic              full,
  output logic              mergeOk,
  output logic              overflow,
  output logic [ADDR_W-1:0] rdStart,
  output logic [SIZE_W-1:0] rdSize
);
  logic [ADDR_W-1:0] entStart [DEPTH];
  logic [SIZE_W-1:0] entSize  [DEPTH];
  logic [ADDR_W-1:0] pendAddr;
  logic [SIZE_W-1:0] pendSize;
  logic [IDX_W-1:0]  hitIdx;
  logic [CNT_W-1:0]  insPos;

  // Search: where the pending access would go, and whether its start exists
  always_comb begin
    hit    = 1'b0;
    hitIdx = '0;
    insPos = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CNT_W'(i) < count) begin
        if (entStart[i] == pendAddr) begin
          hit    = 1'b1;
          hitIdx = IDX_W'(i);
        end
        if (entStart[i] < pendAddr) insPos = insPos + 1'b1;
      end
    end
  end

  assign full = (count == CNT_W'(DEPTH));

  // Merge test between the entry at the cursor and its successor
  logic [ADDR_W-1:0] curStart, nxtStart;
  logic [SIZE_W-1:0] curSize, nxtSize;
  logic [EXT_W-1:0]  reachEnd, spanSize, mergedSize;
  logic              hasNext;

  always_comb begin
    curStart = entStart[cursor];
    curSize  = entSize[cursor];
    nxtStart = '0;
    nxtSize  = '0;
    for (int i = 0; i < DEPTH - 1; i++) begin
      if (IDX_W'(i) == cursor) begin
        nxtStart = entStart[i + 1];
        nxtSize  = entSize[i + 1];
      end
    end
    hasNext    = ({1'b0, cursor} + 1'b1) < (IDX_W + 1)'(count);
    reachEnd   = EXT_W'(curStart) + EXT_W'(curSize) + EXT_W'(GAP);
    spanSize   = EXT_W'(nxtStart) + EXT_W'(nxtSize) - EXT_W'(curStart);
    mergedSize = (spanSize > EXT_W'(curSize)) ? spanSize : EXT_W'(curSize);
    mergeOk    = hasNext && (EXT_W'(nxtStart) <= reachEnd);
  end

  assign rdStart = curStart;
  assign rdSize  = curSize;

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      count    <= '0;
      overflow <= 1'b0;
      pendAddr <= '0;
      pendSize <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        entStart[i] <= '0;
        entSize[i]  <= '0;
      end
    end else if (strobe.latch) begin
      pendAddr <= accAddr;
      pendSize <= accSize;
    end else if (strobe.place) begin
      if (hit) begin
        if (pendSize > entSize[hitIdx]) entSize[hitIdx] <= pendSize;
      end else if (full) begin
        overflow <= 1'b1;
      end else begin
        for (int i = 1; i < DEPTH; i++) begin
          if (CNT_W'(i) > insPos && CNT_W'(i) <= count) begin
            entStart[i] <= entStart[i - 1];
            entSize[i]  <= entSize[i - 1];
          end
        end
        for (int i = 0; i < DEPTH; i++) begin
          if (CNT_W'(i) == insPos) begin
            entStart[i] <= pendAddr;
            entSize[i]  <= pendSize;
          end
        end
        count <= count + 1'b1;
      end
    end else if (strobe.mergeStep && mergeOk) begin
      entSize[cursor] <= SIZE_W'(mergedSize);
      for (int i = 1; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) > cursor && CNT_W'(i + 1) < count) begin
          entStart[i] <= entStart[i + 1];
          entSize[i]  <= entSize[i + 1];
        end
      end
      count <= count - 1'b1;
    end
  end

  // Assertions
  assert_cap_R7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !strobe.clear) |=> overflow);

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (count == '0 && !overflow));

  for (genvar g = 0; g < DEPTH - 1; g++) begin : gChk
    assert_sorted_R3: assert property (@(posedge clk) disable iff (!rstN || strobe.clear)
      (CNT_W'(g + 1) < count) |-> (entStart[g] < entStart[g + 1]));

    assert_gap_R4: assert property (@(posedge clk) disable iff (!rstN || strobe.clear)
      (strobe.settled && CNT_W'(g + 1) < count) |->
        (EXT_W'(entStart[g]) + EXT_W'(entSize[g]) + EXT_W'(GAP) < EXT_W'(entStart[g + 1])));
  end
endmodule

// File: rtl/rc_control.sv
module rc_control import rc_pkg::*; #(
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             batchClear,
  input  logic             accValid,
  input  logic             dumpReq,
  input  logic             outReady,
  input  logic [CNT_W-1:0] count,
  input  logic             hit,
  input  logic             full,
  input  logic             mergeOk,
  output rcStrobe_t        strobe,
  output logic [IDX_W-1:0] cursor,
  output logic             busy,
  output logic             outValid,
  output logic             outLast
);
  rcState_t state;
  logic     scanDone;

  assign busy     = (state != ST_IDLE);
  assign outValid = (state == ST_DUMP);
  assign outLast  = outValid && ((CNT_W'(cursor) + 1'b1) == count);
  assign scanDone = ((CNT_W + 1)'(cursor) + 2'd2) >= (CNT_W + 1)'(count);

  always_comb begin
    strobe           = '0;
    strobe.clear     = batchClear;
    strobe.latch     = (state == ST_IDLE) && accValid && !batchClear;
    strobe.place     = (state == ST_PLACE);
    strobe.mergeStep = (state == ST_MERGE);
    strobe.settled   = (state == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN || batchClear) begin
      state  <= ST_IDLE;
      cursor <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cursor <= '0;
          if (accValid)                       state <= ST_PLACE;
          else if (dumpReq && count != '0)    state <= ST_DUMP;
        end
        ST_PLACE: begin
          cursor <= '0;
          state  <= (!hit && full) ? ST_IDLE : ST_MERGE;
        end
        ST_MERGE: begin
          if (!mergeOk) begin
            if (scanDone) state <= ST_IDLE;
            else          cursor <= cursor + 1'b1;
          end
        end
        ST_DUMP: begin
          if (outReady) begin
            if (outLast) state <= ST_IDLE;
            else         cursor <= cursor + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_rise_R8: assert property (@(posedge clk) disable iff (!rstN || batchClear)
    strobe.latch |=> busy);

  assert_no_latch_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strobe.latch);

  assert_last_R9: assert property (@(posedge clk) disable iff (!rstN || batchClear)
    (outValid && outReady && outLast) |=> !busy);
endmodule

// File: rtl/range_coalescer.sv
module range_coalescer import rc_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 32,
  parameter int DEPTH  = 16,
  parameter int GAP    = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              batch_clear,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              dump_req,
  input  logic              out_ready,
  output logic              busy,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_start,
  output logic [SIZE_W-1:0] out_size,
  output logic              out_last,
  output logic              overflow
);
  rcStrobe_t        strobe;
  logic [IDX_W-1:0] cursor;
  logic [CNT_W-1:0] count;
  logic             hit, full, mergeOk;

  rc_control #(.DEPTH(DEPTH)) ctrlI (
    .clk(clk), .rstN(rst_n), .batchClear(batch_clear), .accValid(acc_valid),
    .dumpReq(dump_req), .outReady(out_ready), .count(count), .hit(hit),
    .full(full), .mergeOk(mergeOk), .strobe(strobe), .cursor(cursor),
    .busy(busy), .outValid(out_valid), .outLast(out_last)
  );

  rc_datapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DEPTH(DEPTH), .GAP(GAP)) dpI (
    .clk(clk), .rstN(rst_n), .strobe(strobe), .cursor(cursor),
    .accAddr(acc_addr), .accSize(acc_size), .count(count), .hit(hit),
    .full(full), .mergeOk(mergeOk), .overflow(overflow),
    .rdStart(out_start), .rdSize(out_size)
  );

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n || batch_clear)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_start) && $stable(out_size)));
endmodule

// File: tb/range_coalescer_tb.sv
module range_coalescer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        batch_clear = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [31:0] acc_size = '0;
  logic        dump_req = 1'b0;
  logic        out_ready = 1'b0;
  logic        busy, out_valid, out_last, overflow;
  logic [31:0] out_start, out_size;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  range_coalescer dut_i (
    .clk(clk), .rst_n(rst_n), .batch_clear(batch_clear), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_size(acc_size), .dump_req(dump_req),
    .out_ready(out_ready), .busy(busy), .out_valid(out_valid),
    .out_start(out_start), .out_size(out_size), .out_last(out_last),
    .overflow(overflow)
  );

  // Reference list and scoreboard queue
  longint mS[$];
  longint mZ[$];
  bit     mOvf = 1'b0;
  longint expS[$];
  longint expZ[$];

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void modelInsert(input longint a, input longint s);
    int pos;
    int k;
    for (int i = 0; i < mS.size(); i++) begin
      if (mS[i] == a) begin
        if (s > mZ[i]) mZ[i] = s;
        pos = -1;
        break;
      end
    end
    if (pos != -1) begin
      if (mS.size() == 16) begin
        mOvf = 1'b1;
        return;
      end
      pos = 0;
      for (int i = 0; i < mS.size(); i++) if (mS[i] < a) pos++;
      mS.insert(pos, a);
      mZ.insert(pos, s);
    end
    k = 0;
    while (k + 1 < mS.size()) begin
      if (mS[k + 1] <= mS[k] + mZ[k] + 32) begin
        if (mS[k + 1] + mZ[k + 1] - mS[k] > mZ[k]) mZ[k] = mS[k + 1] + mZ[k + 1] - mS[k];
        mS.delete(k + 1);
        mZ.delete(k + 1);
      end else begin
        k++;
      end
    end
  endfunction

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic access(input longint a, input longint s);
    waitIdle();
    acc_valid = 1'b1;
    acc_addr  = 32'(a);
    acc_size  = 32'(s);
    modelInsert(a, s);
    @(negedge clk);
    acc_valid = 1'b0;
    check(busy == 1'b1, "R8 busy after strobe", longint'(busy), 1);
    waitIdle();
  endtask

  task automatic clearBatch();
    waitIdle();
    batch_clear = 1'b1;
    @(negedge clk);
    batch_clear = 1'b0;
    mS.delete();
    mZ.delete();
    mOvf = 1'b0;
  endtask

  // Monitor: consume records, pop the scoreboard and compare
  task automatic monitor(input string tag);
    int     cyc = 0;
    bit     held = 1'b0;
    longint hs = 0;
    longint hz = 0;
    longint es, ez;
    bit     elast;
    while (expS.size() != 0) begin
      out_ready = (cyc % 3) != 1;
      cyc++;
      #1;
      if (held) begin
        check(out_valid && out_start == 32'(hs) && out_size == 32'(hz),
              "R9 record held while not ready", longint'(out_start), hs);
      end
      held = out_valid && !out_ready;
      hs = longint'(out_start);
      hz = longint'(out_size);
      if (out_valid && out_ready) begin
        es = expS.pop_front();
        ez = expZ.pop_front();
        elast = (expS.size() == 0);
        check(out_start == 32'(es), {tag, " start"}, longint'(out_start), es);
        check(out_size == 32'(ez), {tag, " size"}, longint'(out_size), ez);
        check(out_last == elast, "R9 last flag", longint'(out_last), longint'(elast));
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(out_valid == 1'b0 && busy == 1'b0, "R9 idle after last", longint'(out_valid), 0);
  endtask

  // Driver for a dump: push the expected records, then request
  task automatic dump(input string tag);
    waitIdle();
    foreach (mS[i]) begin
      expS.push_back(mS[i]);
      expZ.push_back(mZ[i]);
    end
    dump_req = 1'b1;
    @(negedge clk);
    dump_req = 1'b0;
    if (expS.size() == 0) begin
      for (int i = 0; i < 3; i++) begin
        check(out_valid == 1'b0, {tag, " empty dump"}, longint'(out_valid), 0);
        @(negedge clk);
      end
    end else begin
      monitor(tag);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1 busy after reset", longint'(busy), 0);
    check(overflow == 1'b0, "R1 overflow after reset", longint'(overflow), 0);
    check(out_valid == 1'b0, "R1 valid after reset", longint'(out_valid), 0);
    dump("R1");

    // R2 repeated start keeps the larger size; R3 unsorted arrival
    access(100, 4);
    access(100, 8);
    access(100, 2);
    access(300, 4);
    access(200, 2);
    dump("R2_R3");

    // R4 gap of 32 merges, gap of 33 does not
    clearBatch();
    access(1000, 4);
    access(1036, 4);
    access(2000, 4);
    access(2037, 4);
    dump("R4");

    // R5 contained range; R6 chain folding
    clearBatch();
    access(500, 100);
    access(520, 4);
    access(3000, 1);
    access(3100, 1);
    access(3200, 1);
    access(3020, 150);
    dump("R5_R6");

    // R8 strobe during busy is ignored
    clearBatch();
    waitIdle();
    acc_valid = 1'b1;
    acc_addr  = 32'd4000;
    acc_size  = 32'd4;
    modelInsert(4000, 4);
    @(negedge clk);
    check(busy == 1'b1, "R8 busy after strobe", longint'(busy), 1);
    acc_addr = 32'd9000;
    @(negedge clk);
    acc_valid = 1'b0;
    waitIdle();
    dump("R8 ignored strobe");

    // R7 capacity and sticky overflow
    clearBatch();
    for (int i = 0; i < 16; i++) access(10000 + i * 1000, 4);
    check(overflow == 1'b0, "R7 no overflow at capacity", longint'(overflow), 0);
    access(90000, 4);
    check(overflow == 1'b1, "R7 overflow on drop", longint'(overflow), 1);
    access(10000, 16);
    dump("R7");
    check(overflow == 1'b1, "R7 overflow sticky", longint'(overflow), 1);

    // R10 batch clear
    clearBatch();
    check(overflow == 1'b0, "R10 overflow cleared", longint'(overflow), 0);
    dump("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule